// File: doc/BRIEF.md
# Serial DMA Request Line Decoder

This block sits on the host side of a low-pin-count peripheral bus. It receives DMA requests from peripherals over active-low serial request lines, one line per peripheral. All lines are sampled on the shared bus clock. Each line carries short frames. A frame is a low start bit, then a three-bit channel number sent most significant bit first, then one flag bit. A flag of 1 asks for service on that channel. A flag of 0 withdraws an earlier request for that channel.

The block keeps one pending bit per DMA channel. Decoded requests set these bits, and withdrawals clear them. The DMA engine also clears a bit through a clear vector once it has granted service. Channel 4 is not a transfer channel: its pending bit is routed to a separate bus-master request output. Channels 0 to 3 move bytes and channels 5 to 7 move 16-bit words, and each decoded frame carries a width flag that says which kind it is.

Each decoded frame also produces a one-cycle strobe per line with the channel, the flag and the width. The strobe is valid-only and has no ready: a frame on the wire cannot be paused, so there is no back-pressure, and the consumer must take each strobe in the cycle it appears. A line that stays low straight after the flag bit is reported as a framing error.

Top module: `dmarq_serial_decoder`

## Requirements
- R1: While a line's decoder is idle, a sample of 0 on that line is taken as a start bit. The next three samples give the channel number, most significant bit first, where a high level is a 1.
- R2: The sample after the last channel bit is the flag. In the cycle after the clock edge that samples the flag, `evt_vld_o` for that line is 1 for exactly one cycle, with the channel on `evt_ch_o` and the flag on `evt_act_o`. Line l uses bits [3l+2:3l] of `evt_ch_o`.
- R3: `evt_wide_o` is 1 with a decoded frame for channels 5, 6 and 7, and 0 for channels 0 to 4.
- R4: A frame with flag 1 sets that channel's pending bit one cycle after its strobe. Pending bits of channels other than 4 appear on `dma_req_o`, whose bit 4 is always 0. The pending bit of channel 4 appears on `bm_req_o`.
- R5: A frame with flag 0 clears that channel's pending bit one cycle after its strobe, unless a frame with flag 1 for the same channel is applied in the same cycle.
- R6: A 1 on bit c of `svc_clr_i` clears pending bit c at the next clock edge. A set from a decoded frame in the same edge takes priority. A pending bit with no event and no clear keeps its value.
- R7: If a line is sampled low on the clock edge right after the flag sample, `frm_err_o` for that line pulses for one cycle after that edge. That low level and any further low samples produce no frame. Decoding resumes only after the line has been sampled high.
- R8: A single high sample after the flag is enough: a start bit on the very next sample is accepted.
- R9: When both lines complete frames in the same cycle, both are applied. If they name the same channel, the flag-1 result wins.
- R10: Synchronous reset `rst_i` returns both decoders to idle and clears all pending bits, strobes and error pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all sampling on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| rq_n_i | input | 2 | Active-low serial request lines, one per peripheral |
| svc_clr_i | input | 8 | Per-channel pending clear from the DMA engine |
| evt_vld_o | output | 2 | One-cycle decoded-frame strobe per line |
| evt_ch_o | output | 6 | Decoded channel, three bits per line |
| evt_act_o | output | 2 | Decoded flag per line: 1 request, 0 withdraw |
| evt_wide_o | output | 2 | 1 when the decoded channel is a 16-bit channel |
| frm_err_o | output | 2 | One-cycle framing-error pulse per line |
| dma_req_o | output | 8 | Pending DMA requests; bit 4 held 0 |
| bm_req_o | output | 1 | Pending bus-master request (channel 4) |

## Verification
The bench sends asymmetric channel codes such as 6 and 3. A decoder that shifts the bits in reverse order, or that ends one sample early or late, then reports the wrong channel or strobes in the wrong cycle.

It runs frames back to back with only one high sample between them. A decoder that insists on a longer gap would drop the second frame.

It sets and clears the same channel in the same cycle, both from the two lines and from a frame plus the engine's clear vector. A design with the priority reversed leaves the bit clear.

It holds a line low for several samples after the flag. A decoder that takes that level as a new start bit would produce a spurious frame and no error pulse.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_CHAN,
    RX_FLAG,
    RX_GAP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/dmarq_line_rx.sv
module dmarq_line_rx
  import dmarq_pkg::*;
#(
  parameter int CH_W       = 3,
  parameter int WIDE_FIRST = 5
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            rq_n_i,
  output logic            evt_vld_o,
  output logic [CH_W-1:0] evt_ch_o,
  output logic            evt_act_o,
  output logic            evt_wide_o,
  output logic            frm_err_o
);
  localparam int CNT_W = (CH_W > 1) ? $clog2(CH_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CH_W - 1);

  rx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q       <= RX_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      evt_vld_o  <= 1'b0;
      evt_ch_o   <= '0;
      evt_act_o  <= 1'b0;
      evt_wide_o <= 1'b0;
      frm_err_o  <= 1'b0;
    end else begin
      evt_vld_o <= 1'b0;
      frm_err_o <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (!rq_n_i) begin
            st_q  <= RX_CHAN;
            cnt_q <= '0;
          end
        end
        RX_CHAN: begin
          // channel bits arrive MSB first; high level reads as 1
          sh_q <= {sh_q[CH_W-2:0], rq_n_i};
          if (cnt_q == LAST_BIT) st_q <= RX_FLAG;
          else cnt_q <= cnt_q + 1'b1;
        end
        RX_FLAG: begin
          evt_vld_o  <= 1'b1;
          evt_ch_o   <= sh_q;
          evt_act_o  <= rq_n_i;
          evt_wide_o <= (sh_q >= CH_W'(WIDE_FIRST));
          st_q       <= RX_GAP;
        end
        RX_GAP: begin
          if (rq_n_i) begin
            st_q <= RX_IDLE;
          end else begin
            frm_err_o <= 1'b1;
            st_q      <= RX_HOLD;
          end
        end
        RX_HOLD: begin
          if (rq_n_i) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_vld_o |=> !evt_vld_o); // R2

  AST_ERR_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (rst_i)
    frm_err_o |-> $past(evt_vld_o)); // R7

  AST_ERR_NOT_WITH_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(frm_err_o && evt_vld_o)); // R7
endmodule

// File: rtl/dmarq_pend_tbl.sv
module dmarq_pend_tbl #(
  parameter int N_LINES = 2,
  parameter int CH_W    = 3,
  localparam int N_CH   = 1 << CH_W
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [N_LINES-1:0]      evt_vld_i,
  input  logic [N_LINES*CH_W-1:0] evt_ch_i,
  input  logic [N_LINES-1:0]      evt_act_i,
  input  logic [N_CH-1:0]         svc_clr_i,
  output logic [N_CH-1:0]         pend_o
);
  logic [N_CH-1:0] set_v;
  logic [N_CH-1:0] clr_v;

  always_comb begin
    set_v = '0;
    clr_v = svc_clr_i;
    for (int l = 0; l < N_LINES; l++) begin
      if (evt_vld_i[l]) begin
        if (evt_act_i[l]) set_v[evt_ch_i[l*CH_W +: CH_W]] = 1'b1;
        else              clr_v[evt_ch_i[l*CH_W +: CH_W]] = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    always_ff @(posedge clk_i) begin
      if (rst_i)         pend_o[c] <= 1'b0;
      else if (set_v[c]) pend_o[c] <= 1'b1;
      else if (clr_v[c]) pend_o[c] <= 1'b0;
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line_chk
    AST_ACTIVE_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_vld_i[l] && evt_act_i[l]) |=> pend_o[$past(evt_ch_i[l*CH_W +: CH_W])]); // R4

    AST_ABANDON_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_vld_i[l] && !evt_act_i[l] && !set_v[evt_ch_i[l*CH_W +: CH_W]])
      |=> !pend_o[$past(evt_ch_i[l*CH_W +: CH_W])]); // R5
  end

  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_vld_i == '0 && svc_clr_i == '0) |=> $stable(pend_o)); // R6

  AST_RESET_EMPTY: assert property (@(posedge clk_i)
    (!rst_i && $past(rst_i)) |-> pend_o == '0); // R10
endmodule

// File: rtl/dmarq_serial_decoder.sv
module dmarq_serial_decoder #(
  parameter int N_LINES    = 2,
  parameter int CH_W       = 3,
  parameter int BM_CH      = 4,
  parameter int WIDE_FIRST = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [N_LINES-1:0]      rq_n_i,
  input  logic [(1<<CH_W)-1:0]    svc_clr_i,
  output logic [N_LINES-1:0]      evt_vld_o,
  output logic [N_LINES*CH_W-1:0] evt_ch_o,
  output logic [N_LINES-1:0]      evt_act_o,
  output logic [N_LINES-1:0]      evt_wide_o,
  output logic [N_LINES-1:0]      frm_err_o,
  output logic [(1<<CH_W)-1:0]    dma_req_o,
  output logic                    bm_req_o
);
  localparam int N_CH = 1 << CH_W;

  logic [N_CH-1:0] pend;

  for (genvar l = 0; l < N_LINES; l++) begin : g_rx
    dmarq_line_rx #(
      .CH_W       (CH_W),
      .WIDE_FIRST (WIDE_FIRST)
    ) i_rx (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rq_n_i     (rq_n_i[l]),
      .evt_vld_o  (evt_vld_o[l]),
      .evt_ch_o   (evt_ch_o[l*CH_W +: CH_W]),
      .evt_act_o  (evt_act_o[l]),
      .evt_wide_o (evt_wide_o[l]),
      .frm_err_o  (frm_err_o[l])
    );
  end

  dmarq_pend_tbl #(
    .N_LINES (N_LINES),
    .CH_W    (CH_W)
  ) i_pend (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .evt_vld_i (evt_vld_o),
    .evt_ch_i  (evt_ch_o),
    .evt_act_i (evt_act_o),
    .svc_clr_i (svc_clr_i),
    .pend_o    (pend)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_route
    if (c == BM_CH) begin : g_bm
      assign dma_req_o[c] = 1'b0;
    end else begin : g_dma
      assign dma_req_o[c] = pend[c];
    end
  end
  assign bm_req_o = pend[BM_CH];

  AST_BM_OFF_DMA: assert property (@(posedge clk_i) disable iff (rst_i)
    bm_req_o |-> !dma_req_o[BM_CH]); // R4
endmodule

// File: tb/test_dmarq_serial_decoder.sv
module test_dmarq_serial_decoder;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rq_n = 2'b11;
  logic [7:0] svc = '0;
  logic [1:0] evt_vld, evt_act, evt_wide, frm_err;
  logic [5:0] evt_ch;
  logic [7:0] dma_req;
  logic       bm_req;

  typedef struct packed {logic [2:0] ch; logic act; logic wide;} ev_t;
  ev_t q0[$];
  ev_t q1[$];
  int  err_exp[2];
  int  err_seen[2];
  logic [7:0] mdl = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_T/2) clk = ~clk;

  dmarq_serial_decoder i_dmarq_serial_decoder (
    .clk_i(clk), .rst_i(rst), .rq_n_i(rq_n), .svc_clr_i(svc),
    .evt_vld_o(evt_vld), .evt_ch_o(evt_ch), .evt_act_o(evt_act),
    .evt_wide_o(evt_wide), .frm_err_o(frm_err),
    .dma_req_o(dma_req), .bm_req_o(bm_req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic ev_t mk(logic [2:0] c, logic a);
    ev_t e;
    e.ch = c; e.act = a; e.wide = (c >= 3'd5);
    return e;
  endfunction

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < 2; l++) begin
        if (frm_err[l]) err_seen[l]++;
        if (evt_vld[l]) begin
          ev_t got, exp;
          got.ch = evt_ch[l*3 +: 3]; got.act = evt_act[l]; got.wide = evt_wide[l];
          if ((l == 0 && q0.size() == 0) || (l == 1 && q1.size() == 0)) begin
            chk("R2 unexpected strobe", {27'd0, got}, 32'hFFFF);
          end else begin
            exp = (l == 0) ? q0.pop_front() : q1.pop_front();
            chk("R1 channel", {29'd0, got.ch}, {29'd0, exp.ch});
            chk("R2 flag", {31'd0, got.act}, {31'd0, exp.act});
            chk("R3 width", {31'd0, got.wide}, {31'd0, exp.wide});
          end
        end
      end
    end
  end

  function automatic logic bit_at(logic [2:0] c, logic a, int i);
    if (i == 0) return 1'b0;
    if (i == 4) return a;
    return c[3-i];
  endfunction

  task automatic frame2(bit u0, logic [2:0] c0, logic a0,
                        bit u1, logic [2:0] c1, logic a1,
                        logic [7:0] clr_at_gap);
    logic [7:0] st, cl;
    if (u0) q0.push_back(mk(c0, a0));
    if (u1) q1.push_back(mk(c1, a1));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      svc = '0;
      rq_n[0] = u0 ? bit_at(c0, a0, i) : 1'b1;
      rq_n[1] = u1 ? bit_at(c1, a1, i) : 1'b1;
    end
    @(negedge clk);
    rq_n = 2'b11;
    svc  = clr_at_gap;
    st = '0; cl = clr_at_gap;
    if (u0) begin if (a0) st[c0] = 1'b1; else cl[c0] = 1'b1; end
    if (u1) begin if (a1) st[c1] = 1'b1; else cl[c1] = 1'b1; end
    mdl = st | (mdl & ~cl);
  endtask

  task automatic check_pend(string tag);
    @(negedge clk);
    svc = '0;
    chk(tag, {24'd0, dma_req}, {24'd0, mdl & 8'hEF});
    chk(tag, {31'd0, bm_req}, {31'd0, mdl[4]});
  endtask

  task automatic err_frame(int l, logic [2:0] c, logic a, int nlow);
    if (l == 0) q0.push_back(mk(c, a)); else q1.push_back(mk(c, a));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rq_n[l] = bit_at(c, a, i);
    end
    for (int i = 0; i < nlow; i++) begin
      @(negedge clk);
      rq_n[l] = 1'b0;
    end
    err_exp[l]++;
    if (a) mdl[c] = 1'b1; else mdl[c] = 1'b0;
    @(negedge clk);
    rq_n[l] = 1'b1;
  endtask

  initial begin
    #(CLK_T * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset dma", {24'd0, dma_req}, 32'd0);
    chk("R10 reset bm", {31'd0, bm_req}, 32'd0);
    chk("R10 reset strobe", {30'd0, evt_vld}, 32'd0);

    frame2(1, 3'd2, 1, 0, 3'd0, 0, '0); check_pend("R4 set ch2");
    frame2(0, 3'd0, 0, 1, 3'd6, 1, '0); check_pend("R4 set ch6");
    frame2(1, 3'd4, 1, 0, 3'd0, 0, '0); check_pend("R4 bus master ch4");
    frame2(0, 3'd0, 0, 1, 3'd2, 0, '0); check_pend("R5 withdraw ch2");
    frame2(1, 3'd3, 1, 0, 3'd0, 0, '0); check_pend("R1 msb first ch3");

    // R8: second start right after one high sample
    frame2(1, 3'd7, 1, 0, 3'd0, 0, '0);
    frame2(1, 3'd1, 1, 0, 3'd0, 0, '0);
    check_pend("R8 back to back");

    // R6: engine clear, then clear colliding with a set
    @(negedge clk); svc = 8'h80; mdl[7] = 1'b0;
    check_pend("R6 service clear ch7");
    frame2(0, 3'd0, 0, 1, 3'd5, 1, 8'h20); check_pend("R6 set beats clear");
    frame2(1, 3'd5, 0, 0, 3'd0, 0, '0);    check_pend("R5 withdraw ch5");

    // R9: both lines in the same cycle
    frame2(1, 3'd5, 0, 1, 3'd5, 1, '0); check_pend("R9 same ch line1 active");
    frame2(1, 3'd5, 1, 1, 3'd5, 0, '0); check_pend("R9 same ch line0 active");
    frame2(1, 3'd0, 1, 1, 3'd1, 0, '0); check_pend("R9 distinct channels");

    // R7: line held low after the flag
    err_frame(0, 3'd6, 0, 4);
    err_frame(1, 3'd2, 1, 1);
    check_pend("R7 frame before error");
    chk("R7 error line0", err_seen[0], err_exp[0]);
    chk("R7 error line1", err_seen[1], err_exp[1]);
    frame2(1, 3'd0, 0, 0, 3'd0, 0, '0); check_pend("R7 resume after error");
    chk("R7 no error on clean frame", err_seen[0], err_exp[0]);

    // R10: reset with bits pending
    frame2(0, 3'd0, 0, 1, 3'd7, 1, '0); check_pend("R4 set ch7");
    @(negedge clk); rst = 1'b1; mdl = '0;
    @(negedge clk); rst = 1'b0;
    check_pend("R10 reset clears pending");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard empty line0", q0.size(), 0);
    chk("R2 scoreboard empty line1", q1.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule